// File: doc/BRIEF.md
# PWM Output Short-Circuit Guard

This block protects the output stage of a three-phase complementary PWM timer and of a separate single-channel timer. It watches three active-low external request inputs and three complementary output pairs. It turns off the output-enable of a pin group when either of two things happens. The first is an asserted request. The second is both pins of an enabled pair sitting at their active level on the same clock edge. The pads driven by those enables then go high-impedance.

The active level of each monitored pin comes from one of three places:
- one common polarity bit supplied by the timer;
- six per-phase polarity bits supplied by the timer;
- six per-pin polarity bits held in the block's own registers.

An override bit and the timer's select input choose between them. Every fault source latches a sticky flag. A group stays disabled until software clears the flag and the cause is gone. A small word-wide register port sets the pair enables, the polarity, the request routing and the flag clearing.

Top module: `pwm_short_guard`

## Requirements
- R1: After reset all three enables (`oe_cmp`, `oe_single`, `oe_other`) are high and every register, including the flags, reads zero.
- R2: Request 0 (`req_n[0]` low) drives `oe_cmp` low. The enable is still high after the second rising edge following the request and is low after the third, because of the two-stage synchronizer plus the flag register.
- R3: Request 1 (`req_n[1]` low) drives `oe_single` low, with the same three-edge latency.
- R4: With no routing bits set, request 2 leaves all three enables high but still sets flag bit 2.
- R5: Routing register (address 2) bits add targets to each request:
  - request 0: bit0 to the single group, bit1 to the other group;
  - request 1: bit2 to the complementary group, bit3 to the other group;
  - request 2: bit4 to the complementary group, bit5 to the single group, bit6 to the other group.
- R6: Pins are paired as (`pwm_pins[0]`,`[1]`), (`[2]`,`[3]`) and (`[4]`,`[5]`), and each pair is enabled by control (address 0) bit 0, 1 or 2. Both pins of an enabled pair active at one edge sets flag bit 3 and drives `oe_cmp` low after that edge. A disabled pair, or a single active pin, does nothing.
- R7: Polarity value 0 means active-low and 1 means active-high. The source of the active level depends on two bits:
  - override (control bit 3) clear and `tmr_pol_sel`=0: `tmr_pol_common` applies to all pins;
  - override clear and `tmr_pol_sel`=1: `tmr_pol_phase[i]` applies to pin i;
  - override set: register 1 bit i applies to pin i, whatever the timer inputs hold.
- R8: Flags (address 3) are sticky. Bit0, bit1 and bit2 belong to requests 0, 1 and 2, and bit3 to the short fault. Writing 1 to a bit clears it. A clear written while its cause is still present has no effect, and the enable stays low.
- R9: Control (bits 3:0), polarity (bits 5:0) and routing (bits 6:0) read back the value written. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 3 | Asynchronous active-low high-impedance requests |
| pwm_pins | input | 6 | Levels of the three monitored complementary pairs |
| tmr_pol_sel | input | 1 | Timer polarity select: 0 common, 1 per-phase |
| tmr_pol_common | input | 1 | Timer common polarity bit |
| tmr_pol_phase | input | 6 | Timer per-phase polarity bits, one per pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| oe_cmp | output | 1 | Output enable of the complementary PWM group |
| oe_single | output | 1 | Output enable of the single-channel group |
| oe_other | output | 1 | Output enable of the other register-chosen targets |

## Verification
Each result has a fixed latency:
- a request reaches its enable on the third rising edge after it is driven;
- a pair fault reaches `oe_cmp` on the first rising edge;
- a flag clear takes effect on the edge that carries the write.

The driver applies stimulus just after a falling edge. It then pushes an expectation at a known edge count, and the monitor compares it at the next falling edge. For requests, the bench checks both the cycle before the enable drops and the cycle it drops, so an off-by-one latency is caught as well as a wrong value.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;
  localparam int unsigned NUM_REQ   = 3;
  localparam int unsigned NUM_PAIRS = 3;
  localparam int unsigned NUM_PINS  = 2 * NUM_PAIRS;
  localparam int unsigned NUM_FLAGS = NUM_REQ + 1;
  localparam int unsigned FLG_SHORT = NUM_REQ;
  localparam int unsigned ROUTE_W   = 7;
  localparam int unsigned CTRL_W    = NUM_PAIRS + 1;
  localparam int unsigned AW        = 2;
  localparam int unsigned DW        = 8;

  // routing bit positions
  localparam int unsigned RT_R0_SGL = 0;
  localparam int unsigned RT_R0_OTH = 1;
  localparam int unsigned RT_R1_CMP = 2;
  localparam int unsigned RT_R1_OTH = 3;
  localparam int unsigned RT_R2_CMP = 4;
  localparam int unsigned RT_R2_SGL = 5;
  localparam int unsigned RT_R2_OTH = 6;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 2'd0,
    A_PINPOL = 2'd1,
    A_ROUTE  = 2'd2,
    A_FLAGS  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_guard_sync.sv
module pwm_guard_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwm_guard_pairs.sv
module pwm_guard_pairs
  import pwm_guard_pkg::*;
(
  input  logic [NUM_PINS-1:0]  pins,
  input  logic [NUM_PAIRS-1:0] pair_en,
  input  logic                 override_en,
  input  logic [NUM_PINS-1:0]  pin_pol,
  input  logic                 tmr_pol_sel,
  input  logic                 tmr_pol_common,
  input  logic [NUM_PINS-1:0]  tmr_pol_phase,
  output logic                 short_any
);
  logic [NUM_PINS-1:0]  act_lvl;
  logic [NUM_PINS-1:0]  pin_act;
  logic [NUM_PAIRS-1:0] pair_hit;

  // pick the polarity source
  always_comb begin
    if (override_en)      act_lvl = pin_pol;
    else if (tmr_pol_sel) act_lvl = tmr_pol_phase;
    else                  act_lvl = {NUM_PINS{tmr_pol_common}};
  end

  // a pin is active when its level equals its polarity bit
  assign pin_act = ~(pins ^ act_lvl);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pair_hit[g] = pair_en[g] & pin_act[2*g] & pin_act[2*g+1];
  end

  assign short_any = |pair_hit;
endmodule

// File: rtl/pwm_guard_regs.sv
module pwm_guard_regs
  import pwm_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NUM_FLAGS-1:0] flag_set,
  output logic [NUM_PAIRS-1:0] pair_en,
  output logic                 override_en,
  output logic [NUM_PINS-1:0]  pin_pol,
  output logic [ROUTE_W-1:0]   route,
  output logic [NUM_FLAGS-1:0] flags
);
  reg_addr_e            sel;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [NUM_PINS-1:0]  pol_q, pol_d;
  logic [ROUTE_W-1:0]   route_q, route_d;
  logic [NUM_FLAGS-1:0] flag_q, flag_d, clr_mask;
  logic                 ctrl_en, pol_en, route_en;
  logic                 unused_wdata;

  assign sel          = reg_addr_e'(addr);
  assign unused_wdata = ^wdata[DW-1:ROUTE_W];

  // next state
  always_comb begin
    ctrl_en  = we && (sel == A_CTRL);
    pol_en   = we && (sel == A_PINPOL);
    route_en = we && (sel == A_ROUTE);
    ctrl_d   = wdata[CTRL_W-1:0];
    pol_d    = wdata[NUM_PINS-1:0];
    route_d  = wdata[ROUTE_W-1:0];
    clr_mask = (we && (sel == A_FLAGS)) ? wdata[NUM_FLAGS-1:0] : '0;
    // a live cause wins over a clear
    flag_d   = flag_set | (flag_q & ~clr_mask);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pol_q   <= '0;
      route_q <= '0;
      flag_q  <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (pol_en)   pol_q   <= pol_d;
      if (route_en) route_q <= route_d;
      flag_q <= flag_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (sel)
      A_CTRL:   rdata[CTRL_W-1:0]    = ctrl_q;
      A_PINPOL: rdata[NUM_PINS-1:0]  = pol_q;
      A_ROUTE:  rdata[ROUTE_W-1:0]   = route_q;
      A_FLAGS:  rdata[NUM_FLAGS-1:0] = flag_q;
      default:  rdata = '0;
    endcase
  end

  assign pair_en     = ctrl_q[NUM_PAIRS-1:0];
  assign override_en = ctrl_q[NUM_PAIRS];
  assign pin_pol     = pol_q;
  assign route       = route_q;
  assign flags       = flag_q;
endmodule

// File: rtl/pwm_short_guard.sv
module pwm_short_guard
  import pwm_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  req_n,
  input  logic [NUM_PINS-1:0] pwm_pins,
  input  logic                tmr_pol_sel,
  input  logic                tmr_pol_common,
  input  logic [NUM_PINS-1:0] tmr_pol_phase,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                oe_cmp,
  output logic                oe_single,
  output logic                oe_other
);
  logic                 rst_sync_n;
  logic [NUM_REQ-1:0]   req_s_n;
  logic                 short_any;
  logic [NUM_PAIRS-1:0] pair_en;
  logic                 override_en;
  logic [NUM_PINS-1:0]  pin_pol;
  logic [ROUTE_W-1:0]   route;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flag_set;

  pwm_guard_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pwm_guard_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(req_n), .q(req_s_n)
  );

  pwm_guard_pairs u_pairs (
    .pins(pwm_pins), .pair_en(pair_en), .override_en(override_en),
    .pin_pol(pin_pol), .tmr_pol_sel(tmr_pol_sel),
    .tmr_pol_common(tmr_pol_common), .tmr_pol_phase(tmr_pol_phase),
    .short_any(short_any)
  );

  assign flag_set = {short_any, ~req_s_n};

  pwm_guard_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .flag_set(flag_set),
    .pair_en(pair_en), .override_en(override_en), .pin_pol(pin_pol),
    .route(route), .flags(flags)
  );

  // group enables from latched flags and routing
  always_comb begin
    oe_cmp    = ~(flags[0] | flags[FLG_SHORT]
                  | (flags[1] & route[RT_R1_CMP])
                  | (flags[2] & route[RT_R2_CMP]));
    oe_single = ~(flags[1]
                  | (flags[0] & route[RT_R0_SGL])
                  | (flags[2] & route[RT_R2_SGL]));
    oe_other  = ~((flags[0] & route[RT_R0_OTH])
                  | (flags[1] & route[RT_R1_OTH])
                  | (flags[2] & route[RT_R2_OTH]));
  end
endmodule

// File: rtl/pwm_short_guard_chk.sv
module pwm_short_guard_chk
  import pwm_guard_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_REQ-1:0]   req_s_n,
  input logic                 short_any,
  input logic [NUM_FLAGS-1:0] flags,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic                 oe_cmp,
  input logic                 oe_single
);
  p_req0_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_s_n[0] |=> flags[0]);

  p_req2_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_s_n[2] |=> flags[2]);

  p_short_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    short_any |=> flags[FLG_SHORT]);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_SHORT] && !(reg_we && reg_addr == 2'd3 && reg_wdata[FLG_SHORT]))
      |=> flags[FLG_SHORT]);

  p_cmp_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] |-> !oe_cmp);

  p_single_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> !oe_single);
endmodule

bind pwm_short_guard pwm_short_guard_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_s_n(req_s_n), .short_any(short_any),
  .flags(flags), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .oe_cmp(oe_cmp), .oe_single(oe_single)
);

// File: tb/test_pwm_short_guard.sv
`timescale 1ns/1ps
module test_pwm_short_guard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req_n;
  logic [5:0] pwm_pins;
  logic       tmr_pol_sel, tmr_pol_common;
  logic [5:0] tmr_pol_phase;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       oe_cmp, oe_single, oe_other;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [2:0] oe;
    logic [7:0] rd;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pwm_short_guard i_pwm_short_guard (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .pwm_pins(pwm_pins),
    .tmr_pol_sel(tmr_pol_sel), .tmr_pol_common(tmr_pol_common),
    .tmr_pol_phase(tmr_pol_phase), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .oe_cmp(oe_cmp), .oe_single(oe_single), .oe_other(oe_other)
  );

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ({oe_other, oe_single, oe_cmp} !== e.oe || reg_rdata !== e.rd) begin
        errors++;
        $display("FAIL %s: oe={other,single,cmp}=%b rdata=%h, expected oe=%b rdata=%h",
                 e.tag, {oe_other, oe_single, oe_cmp}, reg_rdata, e.oe, e.rd);
      end
    end
  end

  // expectation applies to the state after the next rising edge
  task automatic expect_at(string tag, logic [2:0] eoe, logic [1:0] a, logic [7:0] erd);
    reg_addr = a;
    sb_q.push_back('{tag, eoe, erd});
    @(negedge clk); #1;
  endtask

  task automatic expect_flags(string tag, logic [2:0] eoe, logic [3:0] ef);
    expect_at(tag, eoe, 2'd3, {4'b0, ef});
  endtask

  task automatic wait_edges(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  // request fall: high after 2 edges, low after 3; then release and clear
  task automatic req_trip(string tag, int idx, logic [2:0] eoe);
    req_n[idx] = 1'b0;
    wait_edges(1);
    expect_flags({tag, " not yet"}, 3'b111, 4'b0);
    expect_flags(tag, eoe, 4'(1 << idx));
    req_n[idx] = 1'b1;
    wait_edges(3);
    wr(2'd3, 8'(1 << idx));
  endtask

  initial begin
    rst_n = 1'b0; req_n = 3'b111; pwm_pins = 6'b111111;
    tmr_pol_sel = 1'b0; tmr_pol_common = 1'b0; tmr_pol_phase = 6'b0;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_edges(4);

    // R1 reset state
    expect_flags("R1 flags after reset", 3'b111, 4'b0);
    expect_at("R1 ctrl after reset", 3'b111, 2'd0, 8'h00);
    expect_at("R1 route after reset", 3'b111, 2'd2, 8'h00);

    // R9 readback
    wr(2'd0, 8'hF7);
    expect_at("R9 ctrl readback", 3'b111, 2'd0, 8'h07);
    wr(2'd1, 8'hEA);
    expect_at("R9 pinpol readback", 3'b111, 2'd1, 8'h2A);
    wr(2'd2, 8'hFF);
    expect_at("R9 route readback", 3'b111, 2'd2, 8'h7F);
    wr(2'd2, 8'h00);

    // R2 request 0, then R8 sticky after release
    req_n[0] = 1'b0;
    wait_edges(1);
    expect_flags("R2 req0 before 3rd edge", 3'b111, 4'b0000);
    expect_flags("R2 req0 trips cmp", 3'b110, 4'b0001);
    req_n[0] = 1'b1;
    wait_edges(3);
    expect_flags("R8 stays low after release", 3'b110, 4'b0001);
    wr(2'd3, 8'h01);
    expect_flags("R8 clear restores enable", 3'b111, 4'b0000);

    // R8 clear while cause active is ignored
    req_n[0] = 1'b0;
    wait_edges(3);
    wr(2'd3, 8'h01);
    expect_flags("R8 clear ignored while active", 3'b110, 4'b0001);
    req_n[0] = 1'b1;
    wait_edges(3);
    wr(2'd3, 8'h01);
    expect_flags("R8 cleared after release", 3'b111, 4'b0000);

    // R3 request 1
    req_trip("R3 req1 trips single", 1, 3'b101);
    expect_flags("R3 cleared", 3'b111, 4'b0000);

    // R4 request 2 unrouted
    req_trip("R4 req2 no target", 2, 3'b111);
    expect_flags("R4 cleared", 3'b111, 4'b0000);

    // R5 routing
    wr(2'd2, 8'h03);
    req_trip("R5 req0 to single and other", 0, 3'b000);
    wr(2'd2, 8'h50);
    req_trip("R5 req2 to cmp and other", 2, 3'b010);
    wr(2'd2, 8'h04);
    req_trip("R5 req1 to cmp", 1, 3'b100);
    wr(2'd2, 8'h20);
    req_trip("R5 req2 to single", 2, 3'b101);
    wr(2'd2, 8'h08);
    req_trip("R5 req1 to other", 1, 3'b001);
    wr(2'd2, 8'h00);
    expect_flags("R5 all clear", 3'b111, 4'b0000);

    // R6 pair compare, common active-low
    pwm_pins = 6'b111100;
    expect_flags("R6 pair0 short", 3'b110, 4'b1000);
    pwm_pins = 6'b111111;
    wr(2'd3, 8'h08);
    expect_flags("R6 cleared", 3'b111, 4'b0000);
    wr(2'd0, 8'h06);
    pwm_pins = 6'b111100;
    wait_edges(1);
    expect_flags("R6 disabled pair ignored", 3'b111, 4'b0000);
    pwm_pins = 6'b111111;
    wr(2'd0, 8'h07);
    pwm_pins = 6'b111110;
    wait_edges(1);
    expect_flags("R6 one active pin ignored", 3'b111, 4'b0000);
    pwm_pins = 6'b111111;
    wait_edges(1);

    // R7 common active-high
    tmr_pol_common = 1'b1; pwm_pins = 6'b000000;
    wait_edges(1);
    expect_flags("R7 common high idle", 3'b111, 4'b0000);
    pwm_pins = 6'b001100;
    expect_flags("R7 common high pair1", 3'b110, 4'b1000);
    pwm_pins = 6'b000000;
    wr(2'd3, 8'h08);

    // R7 per-phase polarity
    tmr_pol_sel = 1'b1; tmr_pol_phase = 6'b110000; pwm_pins = 6'b001111;
    wait_edges(1);
    expect_flags("R7 phase idle", 3'b111, 4'b0000);
    pwm_pins = 6'b111111;
    expect_flags("R7 phase pair2", 3'b110, 4'b1000);
    pwm_pins = 6'b001111;
    wr(2'd3, 8'h08);

    // R7 override: pin polarity 0x2A, timer bits ignored
    pwm_pins = 6'b010101;
    wr(2'd0, 8'h0F);
    wait_edges(1);
    expect_flags("R7 override idle", 3'b111, 4'b0000);
    pwm_pins = 6'b011001;
    expect_flags("R7 override pair1", 3'b110, 4'b1000);
    pwm_pins = 6'b010101;
    wr(2'd3, 8'h08);
    expect_flags("R7 override cleared", 3'b111, 4'b0000);

    wait_edges(2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule